// File: doc/BRIEF.md
# Transmit DMA Request Pin Controller

This block drives one active-low output pin of a serial controller channel. The pin has two uses. In request mode it is the DMA request line for the transmit path. It pulls low when the transmit FIFO has room. It releases once a DMA or CPU write is under way. In modem-control mode the same pin simply shows the inverse of a control register bit.

In request mode, a threshold bit chooses how much FIFO room is needed before the request asserts: either the whole FIFO must be empty, or only its exit slot. A second bit chooses when the request releases during a write. With late release, the pin stays low for the whole strobe and lets go only after the strobe ends, which keeps the recovery time the next access needs. With early release, the pin lets go as soon as the strobe begins, so a slow DMA engine cannot mistake a long request for a demand for more data and overrun a full FIFO. After every release caused by a write, the pin is held high for a programmable number of clock cycles before it may assert again.

The write strobe and both FIFO status inputs cross into the clock domain through synchronizer chains. The pin itself comes straight from a flop, so it cannot glitch. The mode, threshold, release and modem bits are register bits that already live in the clock domain.

Top module: `dma_txreq_pin`

## Requirements
- R1: With `reqMode`=1 the pin follows the request logic. With `reqMode`=0 the pin follows the modem-control bit, and the request logic is returned to its idle phase.
- R2: In modem-control mode, `pinN` equals the inverse of `modemBit`, one clock edge after the bit is applied.
- R3: `pinN` is 1 while `rstN` is low. It is also 1 on the first edge at which `chanReset` is sampled high, and that edge puts the request logic back in idle.
- R4: `wholeFifoSel`=1 makes `fifoEmpty` the request condition, and `wholeFifoSel`=0 makes `exitEmpty` the condition. The input that is not selected has no effect. Starting from idle, the pin goes low on the (SYNC_STAGES+1)-th edge after the selected input rises.
- R5: If the selected condition drops while the request is low and no write has begun, the pin returns high on the (SYNC_STAGES+1)-th edge after the drop. No hold-off period follows.
- R6: With `earlyRelease`=0, a rising `wrStrobe` keeps the pin low for the whole strobe. The pin goes high on the (SYNC_STAGES+1)-th edge after the strobe falls.
- R7: With `earlyRelease`=1, the pin goes high on the (SYNC_STAGES+1)-th edge after `wrStrobe` rises, even while the strobe is still high.
- R8: After a release caused by a write, the pin stays high for exactly MIN_HIGH clock cycles when the condition is still true, and then asserts again.
- R9: Leaving request mode while the request is low changes the pin to the modem value on the next edge. Returning to request mode with the condition true asserts the pin on the next edge.
- R10: A write strobe seen while the pin is high in request mode (in idle or during the hold-off) has no effect: the pin stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Channel clock |
| rstN | input | 1 | Asynchronous hardware reset, active low |
| chanReset | input | 1 | Synchronous channel reset, active high |
| reqMode | input | 1 | 1 selects the DMA request function, 0 selects the modem-control function |
| wholeFifoSel | input | 1 | 1 makes the request wait for an empty FIFO, 0 only for an empty exit slot |
| earlyRelease | input | 1 | 1 releases the request at the start of the write strobe, 0 at its end |
| modemBit | input | 1 | Modem-control register bit; the pin shows its inverse |
| fifoEmpty | input | 1 | Whole transmit FIFO empty (asynchronous) |
| exitEmpty | input | 1 | Transmit FIFO exit slot empty (asynchronous) |
| wrStrobe | input | 1 | Write access strobe, active high (asynchronous) |
| pinN | output | 1 | Registered active-low dual-purpose pin |

## Verification
The bench builds the block with SYNC_STAGES=2 and MIN_HIGH=3. Every status change therefore reaches the pin on the third edge, and the hold-off lasts three cycles. This is long enough to tell a correct hold-off from an off-by-one or a missing one. It also lets the early-release case reassert during a write strobe that is still high. Directed sequences cover all four threshold and release combinations, mode changes while the request is low, and channel reset. A long random run compares the pin against a cycle model held in the bench.

// File: rtl/txreq_pkg.sv
package txreq_pkg;

  typedef enum logic [1:0] {
    PH_IDLE    = 2'd0,
    PH_ASSERT  = 2'd1,
    PH_HOLD    = 2'd2,
    PH_RECOVER = 2'd3
  } reqPhase_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadGap;
    logic countGap;
    logic driveLow;
  } ctlStrobe_t;

  // Status from datapath to control
  typedef struct packed {
    logic cond;
    logic wrRise;
    logic wrFall;
    logic gapDone;
  } dpStat_t;

endpackage

// File: rtl/txreq_datapath.sv
module txreq_datapath
  import txreq_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int MIN_HIGH    = 1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       chanReset,
  input  logic       reqMode,
  input  logic       wholeFifoSel,
  input  logic       modemBit,
  input  logic       fifoEmpty,
  input  logic       exitEmpty,
  input  logic       wrStrobe,
  input  ctlStrobe_t ctl,
  output dpStat_t    stat,
  output logic       pinN
);

  localparam int GAP_W = (MIN_HIGH < 2) ? 1 : $clog2(MIN_HIGH + 1);
  localparam logic [GAP_W-1:0] GAP_LOAD = GAP_W'(MIN_HIGH - 1);
  localparam int SIG_N = 3;

  logic [SYNC_STAGES-1:0][SIG_N-1:0] syncPipe;
  logic [SIG_N-1:0] rawIn;
  logic [SIG_N-1:0] lastStage;
  logic             wrSync;
  logic             wrPrev;
  logic [GAP_W-1:0] gapCnt;

  assign rawIn = {wrStrobe, exitEmpty, fifoEmpty};

  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncPipe <= '0;
        else       syncPipe <= rawIn;
      end
    end else begin : g_syncN
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncPipe <= '0;
        else       syncPipe <= {syncPipe[SYNC_STAGES-2:0], rawIn};
      end
    end
  endgenerate

  assign lastStage = syncPipe[SYNC_STAGES-1];
  assign wrSync    = lastStage[2];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) wrPrev <= 1'b0;
    else       wrPrev <= wrSync;
  end

  always_comb begin
    stat.cond    = wholeFifoSel ? lastStage[0] : lastStage[1];
    stat.wrRise  = wrSync & ~wrPrev;
    stat.wrFall  = ~wrSync & wrPrev;
    stat.gapDone = (gapCnt == '0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                              gapCnt <= '0;
    else if (chanReset)                     gapCnt <= '0;
    else if (ctl.loadGap)                   gapCnt <= GAP_LOAD;
    else if (ctl.countGap && gapCnt != '0)  gapCnt <= gapCnt - 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         pinN <= 1'b1;
    else if (chanReset) pinN <= 1'b1;
    else if (!reqMode)  pinN <= ~modemBit;
    else               pinN <= ~ctl.driveLow;
  end

endmodule

// File: rtl/txreq_control.sv
module txreq_control
  import txreq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       chanReset,
  input  logic       reqMode,
  input  logic       earlyRelease,
  input  dpStat_t    stat,
  output ctlStrobe_t ctl,
  output reqPhase_t  phase
);

  reqPhase_t nextPhase;

  always_comb begin
    nextPhase    = phase;
    ctl.loadGap  = 1'b0;
    ctl.countGap = 1'b0;
    if (chanReset || !reqMode) begin
      nextPhase = PH_IDLE;
    end else begin
      unique case (phase)
        PH_IDLE: if (stat.cond) nextPhase = PH_ASSERT;
        PH_ASSERT: begin
          if (stat.wrRise) begin
            if (earlyRelease) begin
              nextPhase   = PH_RECOVER;
              ctl.loadGap = 1'b1;
            end else begin
              nextPhase = PH_HOLD;
            end
          end else if (!stat.cond) begin
            nextPhase = PH_IDLE;
          end
        end
        PH_HOLD: begin
          if (stat.wrFall) begin
            nextPhase   = PH_RECOVER;
            ctl.loadGap = 1'b1;
          end
        end
        PH_RECOVER: begin
          if (stat.gapDone) nextPhase = stat.cond ? PH_ASSERT : PH_IDLE;
          else              ctl.countGap = 1'b1;
        end
        default: nextPhase = PH_IDLE;
      endcase
    end
    ctl.driveLow = (nextPhase == PH_ASSERT) || (nextPhase == PH_HOLD);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) phase <= PH_IDLE;
    else       phase <= nextPhase;
  end

endmodule

// File: rtl/dma_txreq_pin.sv
module dma_txreq_pin
  import txreq_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int MIN_HIGH    = 1
) (
  input  logic clk,
  input  logic rstN,
  input  logic chanReset,
  input  logic reqMode,
  input  logic wholeFifoSel,
  input  logic earlyRelease,
  input  logic modemBit,
  input  logic fifoEmpty,
  input  logic exitEmpty,
  input  logic wrStrobe,
  output logic pinN
);

  ctlStrobe_t ctlBus;
  dpStat_t    statBus;
  reqPhase_t  phase;

  txreq_control u_ctl (
    .clk          (clk),
    .rstN         (rstN),
    .chanReset    (chanReset),
    .reqMode      (reqMode),
    .earlyRelease (earlyRelease),
    .stat         (statBus),
    .ctl          (ctlBus),
    .phase        (phase)
  );

  txreq_datapath #(
    .SYNC_STAGES (SYNC_STAGES),
    .MIN_HIGH    (MIN_HIGH)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .chanReset    (chanReset),
    .reqMode      (reqMode),
    .wholeFifoSel (wholeFifoSel),
    .modemBit     (modemBit),
    .fifoEmpty    (fifoEmpty),
    .exitEmpty    (exitEmpty),
    .wrStrobe     (wrStrobe),
    .ctl          (ctlBus),
    .stat         (statBus),
    .pinN         (pinN)
  );

endmodule

// File: rtl/txreq_checker.sv
module txreq_checker
  import txreq_pkg::*;
(
  input logic      clk,
  input logic      rstN,
  input logic      chanReset,
  input logic      reqMode,
  input logic      earlyRelease,
  input logic      modemBit,
  input logic      pinN,
  input reqPhase_t phase,
  input dpStat_t   statBus
);

  assert_modem_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!reqMode && !chanReset) |=> (pinN == !$past(modemBit)));

  assert_chan_reset_R3: assert property (@(posedge clk) disable iff (!rstN)
    chanReset |=> pinN);

  assert_hold_low_R6: assert property (@(posedge clk) disable iff (!rstN)
    (reqMode && !chanReset && phase == PH_HOLD && !statBus.wrFall) |=> !pinN);

  assert_early_release_R7: assert property (@(posedge clk) disable iff (!rstN)
    (reqMode && !chanReset && earlyRelease && phase == PH_ASSERT && statBus.wrRise) |=> pinN);

  assert_min_high_R8: assert property (@(posedge clk) disable iff (!rstN)
    (reqMode && phase == PH_RECOVER && !statBus.gapDone) |=> pinN);

  assert_ignore_write_R10: assert property (@(posedge clk) disable iff (!rstN)
    (reqMode && phase == PH_IDLE && !statBus.cond) |=> pinN);

endmodule

bind dma_txreq_pin txreq_checker u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .chanReset    (chanReset),
  .reqMode      (reqMode),
  .earlyRelease (earlyRelease),
  .modemBit     (modemBit),
  .pinN         (pinN),
  .phase        (phase),
  .statBus      (statBus)
);

// File: tb/dma_txreq_pin_tb.sv
`timescale 1ns/1ps
module dma_txreq_pin_tb;

  localparam int SYNC = 2;
  localparam int GAP  = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0, chanReset = 1'b0, reqMode = 1'b0, wholeFifoSel = 1'b0;
  logic earlyRelease = 1'b0, modemBit = 1'b0, fifoEmpty = 1'b0, exitEmpty = 1'b0;
  logic wrStrobe = 1'b0;
  logic pinN;

  int total = 0, bad = 0, cycles = 0;
  bit done = 0;

  always #5 clk = ~clk;

  dma_txreq_pin #(.SYNC_STAGES(SYNC), .MIN_HIGH(GAP)) u_dut (
    .clk(clk), .rstN(rstN), .chanReset(chanReset), .reqMode(reqMode),
    .wholeFifoSel(wholeFifoSel), .earlyRelease(earlyRelease), .modemBit(modemBit),
    .fifoEmpty(fifoEmpty), .exitEmpty(exitEmpty), .wrStrobe(wrStrobe), .pinN(pinN)
  );

  // Reference model built from the requirements: phase 0 idle, 1 low, 2 low in write, 3 hold-off
  int   mPhase = 0, mCnt = 0;
  logic mSF [SYNC], mSE [SYNC], mSW [SYNC];
  logic mWrPrev = 1'b0, mPin = 1'b1;

  task automatic modelEdge();
    logic sF, sE, sW, rise, fall, cond;
    int   nx;
    if (!rstN) begin
      mPhase = 0; mCnt = 0; mWrPrev = 1'b0; mPin = 1'b1;
      for (int i = 0; i < SYNC; i++) begin mSF[i] = 0; mSE[i] = 0; mSW[i] = 0; end
      return;
    end
    sF = mSF[SYNC-1]; sE = mSE[SYNC-1]; sW = mSW[SYNC-1];
    rise = sW && !mWrPrev; fall = !sW && mWrPrev;
    cond = wholeFifoSel ? sF : sE;
    nx = mPhase;
    if (chanReset) begin nx = 0; mCnt = 0; end
    else if (!reqMode) nx = 0;
    else case (mPhase)
      0: if (cond) nx = 1;
      1: if (rise) begin
           if (earlyRelease) begin nx = 3; mCnt = GAP - 1; end else nx = 2;
         end else if (!cond) nx = 0;
      2: if (fall) begin nx = 3; mCnt = GAP - 1; end
      default: if (mCnt == 0) nx = cond ? 1 : 0; else mCnt--;
    endcase
    mPhase = nx;
    if (chanReset) mPin = 1'b1;
    else if (!reqMode) mPin = !modemBit;
    else mPin = !(nx == 1 || nx == 2);
    for (int i = SYNC - 1; i > 0; i--) begin
      mSF[i] = mSF[i-1]; mSE[i] = mSE[i-1]; mSW[i] = mSW[i-1];
    end
    mSF[0] = fifoEmpty; mSE[0] = exitEmpty; mSW[0] = wrStrobe;
    mWrPrev = sW;
  endtask

  task automatic chk(string tag, logic got, logic exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: pinN=%0b expected %0b at t=%0t", tag, got, exp, $time);
    end
  endtask

  task automatic chkInt(string tag, int got, int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic step(string tag);
    @(posedge clk);
    modelEdge();
    #1;
    chk(tag, pinN, mPin);
  endtask

  task automatic steps(int n, string tag);
    for (int i = 0; i < n; i++) step(tag);
  endtask

  task automatic setSel(logic v);
    if (wholeFifoSel) fifoEmpty = v; else exitEmpty = v;
  endtask

  task automatic setOther(logic v);
    if (wholeFifoSel) exitEmpty = v; else fifoEmpty = v;
  endtask

  // Measures the high run that starts with the current sample
  task automatic highRun(string tag);
    int n = 1;
    while (pinN && n < 20) begin step(tag); if (pinN) n++; end
    chkInt(tag, n, GAP);
  endtask

  task automatic combo(logic whole, logic early);
    wholeFifoSel = whole; earlyRelease = early; reqMode = 1'b1;
    fifoEmpty = 0; exitEmpty = 0; wrStrobe = 0;
    steps(6, "R4 idle");
    chk("R4 idle high", pinN, 1'b1);
    setOther(1'b1);
    steps(6, "R4 unselected input");
    chk("R4 unselected input ignored", pinN, 1'b1);
    setSel(1'b1);
    steps(2, "R4 latency");
    chk("R4 not yet asserted", pinN, 1'b1);
    step("R4 assert");
    chk("R4 asserted on third edge", pinN, 1'b0);
    wrStrobe = 1'b1;
    steps(2, "R6,R7 strobe sync");
    chk("R6,R7 still low during sync", pinN, 1'b0);
    step("R6,R7 strobe seen");
    if (early) begin
      chk("R7 early release", pinN, 1'b1);
      highRun("R8 hold-off after early release");
      chk("R8 reassert after hold-off", pinN, 1'b0);
      wrStrobe = 1'b0;
      steps(4, "R7 strobe end");
      chk("R7 strobe end no effect", pinN, 1'b0);
    end else begin
      chk("R6 low at strobe start", pinN, 1'b0);
      steps(3, "R6 hold");
      chk("R6 low through strobe", pinN, 1'b0);
      wrStrobe = 1'b0;
      steps(2, "R6 fall sync");
      chk("R6 low until fall seen", pinN, 1'b0);
      step("R6 release");
      chk("R6 release after strobe", pinN, 1'b1);
      highRun("R8 hold-off after late release");
      chk("R8 reassert after hold-off", pinN, 1'b0);
    end
    setSel(1'b0);
    steps(2, "R5 withdraw sync");
    chk("R5 low until drop seen", pinN, 1'b0);
    step("R5 withdraw");
    chk("R5 withdraw high", pinN, 1'b1);
    setOther(1'b0);
    steps(4, "R5 settle");
  endtask

  initial begin
    void'($urandom(32'd20240611));
    steps(3, "R3 hw reset");
    chk("R3 pin high in reset", pinN, 1'b1);
    rstN = 1'b1;
    steps(2, "R3 after reset");
    chk("R3 pin high after reset", pinN, 1'b1);

    // R1, R2: modem-control mode
    reqMode = 1'b0; modemBit = 1'b1; fifoEmpty = 1; exitEmpty = 1;
    step("R2 modem");
    chk("R2 modem bit 1 gives low", pinN, 1'b0);
    modemBit = 1'b0;
    step("R2 modem");
    chk("R2 modem bit 0 gives high", pinN, 1'b1);
    steps(4, "R1 modem ignores fifo");
    chk("R1 fifo status ignored in modem mode", pinN, 1'b1);

    for (int w = 0; w < 2; w++)
      for (int e = 0; e < 2; e++) combo(w[0], e[0]);

    // R10: strobe while idle and high is ignored
    wholeFifoSel = 1'b1; earlyRelease = 1'b0; fifoEmpty = 0; exitEmpty = 0;
    steps(4, "R10 prep");
    wrStrobe = 1'b1; steps(3, "R10 strobe"); wrStrobe = 1'b0;
    steps(4, "R10 strobe");
    chk("R10 write while idle ignored", pinN, 1'b1);
    fifoEmpty = 1'b1;
    steps(3, "R10 later assert");
    chk("R10 normal assert after ignored write", pinN, 1'b0);

    // R9: mode change while request is low
    modemBit = 1'b0; reqMode = 1'b0;
    step("R9 leave request mode");
    chk("R9 modem value next edge", pinN, 1'b1);
    modemBit = 1'b1;
    step("R9 modem");
    chk("R9 modem follows bit", pinN, 1'b0);
    modemBit = 1'b0; reqMode = 1'b1;
    step("R9 return");
    chk("R9 reassert on return", pinN, 1'b0);

    // R3: channel reset while low
    chanReset = 1'b1;
    step("R3 chan reset");
    chk("R3 chan reset forces high", pinN, 1'b1);
    chanReset = 1'b0;
    step("R3 after chan reset");
    chk("R3 idle then asserts", pinN, 1'b0);

    // Random phase against the model
    for (int i = 0; i < 4000; i++) begin
      int r = $urandom % 64;
      if (r < 6)       fifoEmpty = ~fifoEmpty;
      else if (r < 12) exitEmpty = ~exitEmpty;
      else if (r < 18) wrStrobe = ~wrStrobe;
      else if (r == 18) reqMode = ~reqMode;
      else if (r == 19) wholeFifoSel = ~wholeFifoSel;
      else if (r == 20) earlyRelease = ~earlyRelease;
      else if (r == 21) modemBit = ~modemBit;
      chanReset = (r == 22);
      if (reqMode) step("R4,R5,R6,R7,R8,R10 random");
      else         step("R1,R2 random");
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1;
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule